// File: doc/BRIEF.md
# Home Cluster Directory Controller

This block keeps the coherence directory for the memory blocks owned by one home cluster in a two-level coherent machine. Each cluster uses snooping inside itself, and between clusters coherence goes through this directory. Every directory entry holds one of three states: uncached-remote, shared-remote or dirty-remote. It also holds a full presence vector with one bit per cluster. The home cluster's own caches are never recorded in the vector, so a block that is dirty inside the home cluster looks uncached-remote here.

Requests arrive one at a time on a valid/ready handshake. Each request names an operation, the sending cluster, a flag saying whether it came from the home cluster's own bus, a peer cluster, and the block index. From the entry's state the controller does one of three things. It answers from memory, with the number of invalidation acknowledgements the requester must wait for. It forwards the request to the dirty owner, and asks the home bus for a retry when the home cluster was the requester. Or it sends invalidations to the sharing clusters. In each case it rewrites the entry. The owner's sharing writeback and dirty-transfer messages complete the forwarded transactions. A dirty transfer also produces the acknowledgement to the new owner. Data movement, the network and the snoop logic sit outside this block.

Top module: `cdir_home`

## Requirements
- R1: After reset every entry is uncached-remote with an empty vector, and `out_valid`, `inv_valid` and `retry` are low. From the second clock after reset is released, `req_ready` is high.
- R2: A remote read (`req_op`=0, `req_local`=0) to an entry that is not dirty-remote produces a data reply (`out_kind`=0) to the sender with count 0. The sender's vector bit is set and the entry becomes shared-remote.
- R3: A read to a dirty-remote entry produces a forward (`out_kind`=1, `out_excl`=0) to the owner, carrying the requester in `out_peer`/`out_peer_home`. A later sharing writeback (`req_op`=3, sent by the owner, peer = requester) leaves the entry shared-remote with the bits of the owner and the remote requester set.
- R4: A remote read-exclusive (`req_op`=1) to an uncached-remote entry produces a data reply with count 0 and no invalidation. The entry becomes dirty-remote with only the requester's bit set.
- R5: A remote read-exclusive to a shared-remote entry produces a data reply whose count equals the number of sharers other than the requester. `inv_mask` holds exactly those sharers (bit i = cluster i). The entry becomes dirty-remote owned by the requester.
- R6: A remote read-exclusive to a dirty-remote entry produces an exclusive forward (`out_excl`=1) to the owner. A later dirty-transfer message (`req_op`=4, peer = requester) produces an acknowledgement (`out_kind`=2) to the requester and records it as the only owner.
- R7: A home-bus read-exclusive to a shared-remote entry produces a data reply to the home bus (`out_home`=1). It invalidates every remote sharer, with the count equal to their number, and leaves the entry uncached-remote.
- R8: A home-bus read or read-exclusive to a dirty-remote entry raises `retry` in the same cycle as the forward, with `out_peer_home`=1. A dirty transfer whose peer is the home bus acknowledges the home bus and leaves the entry uncached-remote. A sharing writeback whose peer is the home bus leaves only the owner's bit set.
- R9: A writeback from a remote cluster (`req_op`=2, `req_local`=0) makes the entry uncached-remote with an empty vector.
- R10: A home-bus read to an entry that is not dirty-remote is answered from memory to the home bus and leaves the entry unchanged. A home-bus writeback changes nothing.
- R11: Every reply, forward, acknowledgement and invalidation appears exactly one cycle after the request is accepted and lasts one cycle. Writebacks and sharing writebacks produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_op | input | 3 | 0 read, 1 read-exclusive, 2 writeback, 3 sharing writeback, 4 dirty transfer |
| req_src | input | CW | Sending cluster |
| req_local | input | 1 | Request from home bus; for codes 3 and 4, the peer is the home bus |
| req_peer | input | CW | Original requester, used by codes 3 and 4 |
| req_idx | input | IW | Directory entry index |
| out_valid | output | 1 | A reply, forward or acknowledgement is present |
| out_kind | output | 2 | 0 data, 1 forward, 2 acknowledgement |
| out_dest | output | CW | Destination cluster |
| out_home | output | 1 | Destination is the home bus |
| out_excl | output | 1 | Forward is read-exclusive |
| out_peer | output | CW | Requester carried with a forward |
| out_peer_home | output | 1 | Forward's requester is the home bus |
| out_inv_cnt | output | NW | Acknowledgements to expect, in a data reply |
| inv_valid | output | 1 | Invalidations issued |
| inv_mask | output | N_CL | Clusters to invalidate |
| retry | output | 1 | Home bus must retry its request |

## Verification
All outputs are registered. So every result of a request accepted at a clock edge is visible at the falling edge that follows that edge. A request is driven at one falling edge and accepted at the next rising edge. The bench samples the reply at the falling edge after that, and checks at the falling edge after that one that the reply is gone. The directory has no read-back port, so each state change is checked one request later, through the forward target or the invalidation count that the next request gets back.

// File: rtl/cdir_pkg.sv
package cdir_pkg;
    typedef enum logic [1:0] {
        ST_UNC = 2'd0,
        ST_SHR = 2'd1,
        ST_DRT = 2'd2
    } dstate_e;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_READX = 3'd1,
        OP_WBACK = 3'd2,
        OP_SHWB  = 3'd3,
        OP_DXFER = 3'd4
    } dop_e;

    typedef enum logic [1:0] {
        K_DATA = 2'd0,
        K_FWD  = 2'd1,
        K_ACK  = 2'd2
    } kind_e;
endpackage

// File: rtl/cdir_popcnt.sv
module cdir_popcnt #(
    parameter int N  = 8,
    localparam int NW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [NW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + NW'(vec[i]);
        end
    end
endmodule

// File: rtl/cdir_prienc.sv
module cdir_prienc #(
    parameter int N  = 8,
    localparam int CW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] first
);
    // lowest set bit wins; the directory keeps a single bit for a dirty owner
    always_comb begin
        first = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) first = CW'(i);
        end
    end
endmodule

// File: rtl/cdir_store.sv
module cdir_store
    import cdir_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int N_CL  = 8,
    localparam int IW = $clog2(N_ENT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   rd_idx,
    output logic [1:0]      rd_state,
    output logic [N_CL-1:0] rd_vec,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [1:0]      wr_state,
    input  logic [N_CL-1:0] wr_vec
);
    logic [1:0]      st_all  [N_ENT];
    logic [N_CL-1:0] vec_all [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic [1:0]      st_d,  st_q;
        logic [N_CL-1:0] vec_d, vec_q;

        always_comb begin
            st_d  = st_q;
            vec_d = vec_q;
            if (wr_en && wr_idx == IW'(g)) begin
                st_d  = wr_state;
                vec_d = wr_vec;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= ST_UNC;
                vec_q <= '0;
            end else begin
                st_q  <= st_d;
                vec_q <= vec_d;
            end
        end

        assign st_all[g]  = st_q;
        assign vec_all[g] = vec_q;
    end

    assign rd_state = st_all[rd_idx];
    assign rd_vec   = vec_all[rd_idx];

    // R4 / R6: a dirty entry names exactly one owner
    p_dirty_one_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == ST_DRT) |-> $onehot(wr_vec));

    // R9: an uncached entry never keeps presence bits
    p_uncached_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == ST_UNC) |-> (wr_vec == '0));

    // R2 / R3: a shared entry has at least one remote holder
    p_shared_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == ST_SHR) |-> (wr_vec != '0));
endmodule

// File: rtl/cdir_home.sv
module cdir_home
    import cdir_pkg::*;
#(
    parameter int N_CL  = 8,
    parameter int N_ENT = 16,
    localparam int CW = $clog2(N_CL),
    localparam int IW = $clog2(N_ENT),
    localparam int NW = $clog2(N_CL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [2:0]      req_op,
    input  logic [CW-1:0]   req_src,
    input  logic            req_local,
    input  logic [CW-1:0]   req_peer,
    input  logic [IW-1:0]   req_idx,
    output logic            out_valid,
    output logic [1:0]      out_kind,
    output logic [CW-1:0]   out_dest,
    output logic            out_home,
    output logic            out_excl,
    output logic [CW-1:0]   out_peer,
    output logic            out_peer_home,
    output logic [NW-1:0]   out_inv_cnt,
    output logic            inv_valid,
    output logic [N_CL-1:0] inv_mask,
    output logic            retry
);
    typedef struct packed {
        logic            ready;
        logic            valid;
        logic [1:0]      kind;
        logic [CW-1:0]   dest;
        logic            home;
        logic            excl;
        logic [CW-1:0]   peer;
        logic            peer_home;
        logic [NW-1:0]   cnt;
        logic            inv_v;
        logic [N_CL-1:0] inv_m;
        logic            retry;
    } outs_t;

    outs_t out_d, out_q;

    logic [1:0]      rd_state;
    logic [N_CL-1:0] rd_vec;
    logic            wr_en;
    logic [1:0]      wr_state;
    logic [N_CL-1:0] wr_vec;
    logic [N_CL-1:0] src_bit, peer_bit, others;
    logic [CW-1:0]   owner;
    logic [NW-1:0]   others_cnt;
    logic            accept;

    cdir_store #(.N_ENT(N_ENT), .N_CL(N_CL)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .rd_state (rd_state),
        .rd_vec   (rd_vec),
        .wr_en    (wr_en),
        .wr_idx   (req_idx),
        .wr_state (wr_state),
        .wr_vec   (wr_vec)
    );

    cdir_prienc #(.N(N_CL)) u_owner (.vec(rd_vec), .first(owner));
    cdir_popcnt #(.N(N_CL)) u_cnt   (.vec(others), .count(others_cnt));

    assign accept   = req_valid && out_q.ready;
    assign src_bit  = N_CL'(1) << req_src;
    assign peer_bit = N_CL'(1) << req_peer;
    // sharers to invalidate: a remote requester keeps its own copy
    assign others   = rd_vec & ~(req_local ? '0 : src_bit);

    always_comb begin
        out_d       = '0;
        out_d.ready = 1'b1;
        wr_en       = 1'b0;
        wr_state    = rd_state;
        wr_vec      = rd_vec;
        if (accept) begin
            case (dop_e'(req_op))
                OP_READ, OP_READX: begin
                    out_d.valid = 1'b1;
                    if (rd_state == ST_DRT) begin
                        out_d.kind      = K_FWD;
                        out_d.dest      = owner;
                        out_d.excl      = (dop_e'(req_op) == OP_READX);
                        out_d.peer      = req_src;
                        out_d.peer_home = req_local;
                        out_d.retry     = req_local;
                    end else begin
                        out_d.kind = K_DATA;
                        out_d.dest = req_src;
                        out_d.home = req_local;
                        wr_en      = 1'b1;
                        if (dop_e'(req_op) == OP_READ) begin
                            if (!req_local) begin
                                wr_state = ST_SHR;
                                wr_vec   = rd_vec | src_bit;
                            end
                        end else begin
                            if (rd_state == ST_SHR) begin
                                out_d.cnt   = others_cnt;
                                out_d.inv_v = (others != '0);
                                out_d.inv_m = others;
                            end
                            wr_state = req_local ? ST_UNC : ST_DRT;
                            wr_vec   = req_local ? '0 : src_bit;
                        end
                    end
                end
                OP_WBACK: begin
                    if (!req_local) begin
                        wr_en    = 1'b1;
                        wr_state = ST_UNC;
                        wr_vec   = '0;
                    end
                end
                OP_SHWB: begin
                    wr_en    = 1'b1;
                    wr_state = ST_SHR;
                    wr_vec   = src_bit | (req_local ? '0 : peer_bit);
                end
                OP_DXFER: begin
                    out_d.valid = 1'b1;
                    out_d.kind  = K_ACK;
                    out_d.dest  = req_peer;
                    out_d.home  = req_local;
                    wr_en       = 1'b1;
                    wr_state    = req_local ? ST_UNC : ST_DRT;
                    wr_vec      = req_local ? '0 : peer_bit;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign req_ready     = out_q.ready;
    assign out_valid     = out_q.valid;
    assign out_kind      = out_q.kind;
    assign out_dest      = out_q.dest;
    assign out_home      = out_q.home;
    assign out_excl      = out_q.excl;
    assign out_peer      = out_q.peer;
    assign out_peer_home = out_q.peer_home;
    assign out_inv_cnt   = out_q.cnt;
    assign inv_valid     = out_q.inv_v;
    assign inv_mask      = out_q.inv_m;
    assign retry         = out_q.retry;

    p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> req_ready);

    p_retry_with_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> (out_valid && out_kind == K_FWD && out_peer_home));

    p_count_equals_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == K_DATA) |-> (out_inv_cnt == NW'($countones(inv_mask))));

    p_requester_not_invalidated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !out_home) |-> !inv_mask[out_dest]);

    p_invalidate_only_with_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (out_valid && out_kind == K_DATA));

    p_reply_next_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op == OP_READ || req_op == OP_READX || req_op == OP_DXFER))
        |=> out_valid);

    p_silent_writeback_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op == OP_WBACK || req_op == OP_SHWB)) |=> !out_valid);
endmodule

// File: tb/tb_cdir_home.sv
`timescale 1ns/1ps
module tb_cdir_home;
    localparam int N_CL = 8;
    localparam int N_ENT = 16;
    localparam int CW = $clog2(N_CL);
    localparam int IW = $clog2(N_ENT);
    localparam int NW = $clog2(N_CL + 1);

    localparam logic [2:0] RD = 3'd0, RX = 3'd1, WB = 3'd2, SW = 3'd3, DX = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [CW-1:0] req_src = '0;
    logic req_local = 1'b0;
    logic [CW-1:0] req_peer = '0;
    logic [IW-1:0] req_idx = '0;
    logic req_ready, out_valid, out_home, out_excl, out_peer_home, inv_valid, retry;
    logic [1:0] out_kind;
    logic [CW-1:0] out_dest, out_peer;
    logic [NW-1:0] out_inv_cnt;
    logic [N_CL-1:0] inv_mask;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cdir_home #(.N_CL(N_CL), .N_ENT(N_ENT)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_src(req_src), .req_local(req_local), .req_peer(req_peer),
        .req_idx(req_idx), .out_valid(out_valid), .out_kind(out_kind), .out_dest(out_dest),
        .out_home(out_home), .out_excl(out_excl), .out_peer(out_peer),
        .out_peer_home(out_peer_home), .out_inv_cnt(out_inv_cnt), .inv_valid(inv_valid),
        .inv_mask(inv_mask), .retry(retry)
    );

    task automatic chk(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // drive at a falling edge, accepted at the next rising edge, result seen at the next falling edge
    task automatic send(logic [2:0] op, int src, bit loc, int peer, int idx);
        @(negedge clk);
        req_op = op; req_src = CW'(src); req_local = loc; req_peer = CW'(peer);
        req_idx = IW'(idx); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic exp_data(string tag, int dest, bit home, int cnt, int mask);
        chk(tag, "valid", out_valid, 1);
        chk(tag, "kind", out_kind, 0);
        if (!home) chk(tag, "dest", out_dest, dest);
        chk(tag, "home", out_home, home);
        chk(tag, "count", out_inv_cnt, cnt);
        chk(tag, "inv_valid", inv_valid, mask != 0);
        chk(tag, "inv_mask", inv_mask, mask);
        chk(tag, "retry", retry, 0);
    endtask

    task automatic exp_fwd(string tag, int dest, int peer, bit peer_home, bit excl);
        chk(tag, "valid", out_valid, 1);
        chk(tag, "kind", out_kind, 1);
        chk(tag, "dest", out_dest, dest);
        if (!peer_home) chk(tag, "peer", out_peer, peer);
        chk(tag, "peer_home", out_peer_home, peer_home);
        chk(tag, "excl", out_excl, excl);
        chk(tag, "retry", retry, peer_home);
        chk(tag, "inv_valid", inv_valid, 0);
    endtask

    task automatic exp_ack(string tag, int dest, bit home);
        chk(tag, "valid", out_valid, 1);
        chk(tag, "kind", out_kind, 2);
        if (!home) chk(tag, "dest", out_dest, dest);
        chk(tag, "home", out_home, home);
    endtask

    task automatic exp_none(string tag);
        chk(tag, "valid", out_valid, 0);
        chk(tag, "inv_valid", inv_valid, 0);
        chk(tag, "retry", retry, 0);
    endtask

    task automatic t_reset;
        chk("R1", "valid", out_valid, 0);
        chk("R1", "inv_valid", inv_valid, 0);
        chk("R1", "retry", retry, 0);
        chk("R1", "ready", req_ready, 1);
        send(RX, 0, 0, 0, 0);
        exp_data("R1 entry empty", 0, 0, 0, 0);
        send(RX, 2, 0, 0, 13);
        exp_data("R1 entry 13 empty", 2, 0, 0, 0);
    endtask

    task automatic t_remote_read;
        send(RD, 2, 0, 0, 3);
        exp_data("R2 first sharer", 2, 0, 0, 0);
        send(RD, 5, 0, 0, 3);
        exp_data("R2 second sharer", 5, 0, 0, 0);
    endtask

    task automatic t_readx_shared;
        send(RX, 7, 0, 0, 3);
        exp_data("R5 sharers 2,5", 7, 0, 2, 'h24);
    endtask

    task automatic t_read_forward;
        send(RD, 1, 0, 0, 3);
        exp_fwd("R3 read to dirty", 7, 1, 0, 0);
        send(SW, 7, 0, 1, 3);
        exp_none("R3 sharing writeback silent");
        send(RX, 0, 0, 0, 3);
        exp_data("R3 shared by 1,7", 0, 0, 2, 'h82);
    endtask

    task automatic t_readx_dirty;
        send(RX, 4, 0, 0, 5);
        exp_data("R4 uncached grant", 4, 0, 0, 0);
        send(RX, 6, 0, 0, 5);
        exp_fwd("R6 exclusive forward", 4, 6, 0, 1);
        send(DX, 4, 0, 6, 5);
        exp_ack("R6 transfer ack", 6, 0);
        send(RD, 2, 0, 0, 5);
        exp_fwd("R6 new owner", 6, 2, 0, 0);
    endtask

    task automatic t_local_dirty;
        send(RX, 0, 1, 0, 3);
        exp_fwd("R8 home readx", 0, 0, 1, 1);
        send(DX, 0, 1, 0, 3);
        exp_ack("R8 home ack", 0, 1);
        send(RX, 3, 0, 0, 3);
        exp_data("R8 uncached after transfer", 3, 0, 0, 0);
        send(RD, 0, 1, 0, 3);
        exp_fwd("R8 home read", 3, 0, 1, 0);
        send(SW, 3, 1, 0, 3);
        exp_none("R8 home sharing writeback");
        send(RX, 5, 0, 0, 3);
        exp_data("R8 owner only sharer", 5, 0, 1, 'h08);
    endtask

    task automatic t_local_readx_shared;
        send(RD, 1, 0, 0, 7);
        exp_data("R7 setup 1", 1, 0, 0, 0);
        send(RD, 2, 0, 0, 7);
        exp_data("R7 setup 2", 2, 0, 0, 0);
        send(RX, 0, 1, 0, 7);
        exp_data("R7 home readx", 0, 1, 2, 'h06);
        send(RX, 5, 0, 0, 7);
        exp_data("R7 entry uncached", 5, 0, 0, 0);
    endtask

    task automatic t_writeback;
        send(WB, 6, 0, 0, 5);
        exp_none("R9 writeback silent");
        send(RX, 1, 0, 0, 5);
        exp_data("R9 uncached after writeback", 1, 0, 0, 0);
    endtask

    task automatic t_local_noeffect;
        send(RD, 0, 1, 0, 9);
        exp_data("R10 home read", 0, 1, 0, 0);
        send(RX, 4, 0, 0, 9);
        exp_data("R10 still uncached", 4, 0, 0, 0);
        send(WB, 0, 1, 0, 3);
        exp_none("R10 home writeback");
        send(RD, 2, 0, 0, 3);
        exp_fwd("R10 owner kept", 5, 2, 0, 0);
    endtask

    task automatic t_self_sharer;
        send(RD, 1, 0, 0, 11);
        exp_data("R5 setup 1", 1, 0, 0, 0);
        send(RD, 2, 0, 0, 11);
        exp_data("R5 setup 2", 2, 0, 0, 0);
        send(RX, 1, 0, 0, 11);
        exp_data("R5 requester excluded", 1, 0, 1, 'h04);
    endtask

    task automatic t_timing;
        send(RD, 6, 0, 0, 14);
        exp_data("R11 reply due", 6, 0, 0, 0);
        @(negedge clk);
        exp_none("R11 one cycle only");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_remote_read();
        t_readx_shared();
        t_read_forward();
        t_readx_dirty();
        t_local_dirty();
        t_local_readx_shared();
        t_writeback();
        t_local_noeffect();
        t_self_sharer();
        t_timing();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule